// File: doc/BRIEF.md
# Two-Input Priority Merge with Side Queue

This block joins two streams of thread words onto one registered output. The first input, the primary stream, always wins the output. The second input, the secondary stream, is never dropped when it loses. A secondary word that arrives in the same cycle as a primary word is parked in an internal queue. Parked words leave the queue, in arrival order, only in cycles when neither input offers a word. A fresh secondary word takes precedence over the parked backlog.

Each input carries a valid flag, and each input has a pause output back to its producer. A word is taken in a cycle when its valid is high and its pause is low. The consumer of the output drives a pause input. While that pause is high, the output register holds its word and both inputs are paused. The arbitration decodes a three-bit selection code {primary valid, secondary valid, queue non-empty}, with the primary valid as the most significant bit. The output word appears one clock after the cycle in which it is selected.

Top module: `prio_merge_router`

## Requirements
- R1: After reset the output valid is 0, the output data is all zeros, the queue is empty, and with the output pause low both input pauses are low.
- R2: With code 000 (no input valid, queue empty) and no output pause, the next output has valid 0 and data all zeros.
- R3: With code 001 (only the queue holds words) and no output pause, the oldest parked word is output on the next cycle and removed. Parked words come out in the order they were parked.
- R4: With codes 010 and 011 (secondary valid, primary idle), the secondary word is output on the next cycle, and the queue contents are neither read nor changed.
- R5: With codes 100 and 101 (primary valid, secondary idle), the primary word is output on the next cycle, and the queue keeps its contents.
- R6: With codes 110 and 111 and the queue not full, the primary word is output on the next cycle. In the same cycle the secondary word is parked in the queue, and it later comes out through R3.
- R7: When the primary is valid and the queue is full, the secondary pause is high, so the secondary word is not taken. The primary word still passes to the output.
- R8: While the output pause is high, the output valid and data hold their values, both input pauses are high, and the queue is neither written nor read.
- R9: The queue holds exactly DEPTH words. After DEPTH parks with no drains, a further secondary word is refused, and exactly DEPTH parked words drain out afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_valid | input | 1 | Primary stream word valid |
| hi_data | input | DATA_W | Primary stream word |
| hi_pause | output | 1 | Primary stream must hold its word |
| lo_valid | input | 1 | Secondary stream word valid |
| lo_data | input | DATA_W | Secondary stream word |
| lo_pause | output | 1 | Secondary stream must hold its word |
| out_valid | output | 1 | Registered output word valid |
| out_data | output | DATA_W | Registered output word |
| out_pause | input | 1 | Consumer asks the output to hold |

## Verification
Forwarding a primary word and parking a secondary word happen in the same cycle under codes 110 and 111. The bench provokes this by presenting both inputs together. It checks that the primary word reaches the output one clock later, and that the secondary word appears later, in order, during idle cycles. The same overlap is pushed until the queue is full, where the bench expects the secondary pause to rise while the primary word still passes. A second overlap tests a consumer stall against pending words on both inputs: the bench expects the output to hold and no word to be lost when the stall ends.

// File: rtl/prio_merge_pkg.sv
// Package: shared types for the two-input priority merge.
// Assumes: nothing; holds only type and helper definitions.
package prio_merge_pkg;

    // Source chosen to load the output register in a cycle.
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_QUEUE = 2'd1,
        SRC_LO    = 2'd2,
        SRC_HI    = 2'd3
    } src_t;

    // Build the selection code {primary valid, secondary valid, queue non-empty}.
    function automatic logic [2:0] make_code(input logic hv, input logic lv, input logic qn);
        return {hv, lv, qn};
    endfunction

endpackage

// File: rtl/pm_queue.sv
// Module: pm_queue
// Circular side queue for parked secondary words. Supports a push and a
// pop in the same cycle. Assumes: the caller never pops while empty; a
// push while full without a pop is dropped, so the caller must prevent it.
module pm_queue #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     cnt;
    logic              do_push;
    logic              do_pop;

    // Qualify push and pop against the occupancy.
    always_comb begin
        do_pop  = pop && (cnt != '0);
        do_push = push && ((cnt != FULL_CNT) || do_pop);
    end

    // Store a pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Expose the head word and the occupancy flags.
    always_comb begin
        head_data = mem[rd_ptr];
        empty     = (cnt == '0);
        full      = (cnt == FULL_CNT);
        count     = cnt;
    end

endmodule

// File: rtl/pm_arbiter.sv
// Module: pm_arbiter
// Decodes the three-bit selection code into the output source, the queue
// push and pop, and the upstream pauses. Purely combinational.
// Assumes: the output pause freezes all movement for that cycle.
module pm_arbiter
    import prio_merge_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              hi_valid,
    input  logic [DATA_W-1:0] hi_data,
    input  logic              lo_valid,
    input  logic [DATA_W-1:0] lo_data,
    input  logic              q_nonempty,
    input  logic              q_full,
    input  logic [DATA_W-1:0] q_head,
    input  logic              out_pause,
    output logic              hi_pause,
    output logic              lo_pause,
    output logic              q_push,
    output logic              q_pop,
    output logic              load,
    output logic              nxt_valid,
    output logic [DATA_W-1:0] nxt_data
);
    logic [2:0] code;
    src_t       src;

    // Form the selection code and choose the output source.
    always_comb begin
        code = make_code(hi_valid, lo_valid, q_nonempty);
        unique case (code)
            3'b000:          src = SRC_IDLE;
            3'b001:          src = SRC_QUEUE;
            3'b010, 3'b011:  src = SRC_LO;
            default:         src = SRC_HI;
        endcase
    end

    // Derive the pauses and the queue operations from the source.
    always_comb begin
        hi_pause = out_pause;
        lo_pause = out_pause || (hi_valid && q_full);
        load     = !out_pause;
        q_pop    = !out_pause && (src == SRC_QUEUE);
        q_push   = !out_pause && hi_valid && lo_valid && !q_full;
    end

    // Select the word that loads the output register.
    always_comb begin
        case (src)
            SRC_QUEUE: begin nxt_valid = 1'b1; nxt_data = q_head;  end
            SRC_LO:    begin nxt_valid = 1'b1; nxt_data = lo_data; end
            SRC_HI:    begin nxt_valid = 1'b1; nxt_data = hi_data; end
            default:   begin nxt_valid = 1'b0; nxt_data = '0;      end
        endcase
    end

endmodule

// File: rtl/pm_out_reg.sv
// Module: pm_out_reg
// Output stage register; loads a new word when enabled and holds otherwise.
// Assumes: load is low exactly when the consumer pauses.
module pm_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              nxt_valid,
    input  logic [DATA_W-1:0] nxt_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Capture or hold the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= nxt_valid;
            out_data  <= nxt_data;
        end
    end

endmodule

// File: rtl/prio_merge_router.sv
// Module: prio_merge_router
// Merges a primary and a secondary thread stream onto one registered output.
// Secondary words that lose to the primary are parked in a side queue.
// Assumes: valid/pause handshake; a word moves when valid && !pause.
module prio_merge_router #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_valid,
    input  logic [DATA_W-1:0] hi_data,
    output logic              hi_pause,
    input  logic              lo_valid,
    input  logic [DATA_W-1:0] lo_data,
    output logic              lo_pause,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_pause
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              q_push;
    logic              q_pop;
    logic              q_empty;
    logic              q_full;
    logic [DATA_W-1:0] q_head;
    logic [CW-1:0]     q_count;
    logic              load;
    logic              nxt_valid;
    logic [DATA_W-1:0] nxt_data;

    pm_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (lo_data),
        .pop       (q_pop),
        .head_data (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count)
    );

    pm_arbiter #(.DATA_W(DATA_W)) u_arb (
        .hi_valid   (hi_valid),
        .hi_data    (hi_data),
        .lo_valid   (lo_valid),
        .lo_data    (lo_data),
        .q_nonempty (!q_empty),
        .q_full     (q_full),
        .q_head     (q_head),
        .out_pause  (out_pause),
        .hi_pause   (hi_pause),
        .lo_pause   (lo_pause),
        .q_push     (q_push),
        .q_pop      (q_pop),
        .load       (load),
        .nxt_valid  (nxt_valid),
        .nxt_data   (nxt_data)
    );

    pm_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .nxt_valid (nxt_valid),
        .nxt_data  (nxt_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/prio_merge_router_chk.sv
// Module: prio_merge_router_chk
// Checker attached to prio_merge_router; observes ports and queue occupancy.
module prio_merge_router_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       hi_valid,
    input logic [DATA_W-1:0]          hi_data,
    input logic                       hi_pause,
    input logic                       lo_valid,
    input logic [DATA_W-1:0]          lo_data,
    input logic                       lo_pause,
    input logic                       out_valid,
    input logic [DATA_W-1:0]          out_data,
    input logic                       out_pause,
    input logic [$clog2(DEPTH+1)-1:0] q_count
);
    localparam int CW = $clog2(DEPTH + 1);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_valid && !lo_valid && q_count == '0 && !out_pause)
        |=> (!out_valid && out_data == '0));

    assert_lo_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_valid && lo_valid && !lo_pause)
        |=> (out_valid && out_data == $past(lo_data) && q_count == $past(q_count)));

    assert_hi_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid && !hi_pause) |=> (out_valid && out_data == $past(hi_data)));

    assert_park_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid && lo_valid && !lo_pause) |=> (q_count == $past(q_count) + 1'b1));

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid && q_count == CW'(DEPTH)) |-> lo_pause);

    assert_hold_on_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_pause |=> ($stable(out_valid) && $stable(out_data) && $stable(q_count)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));

endmodule

bind prio_merge_router prio_merge_router_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_valid  (hi_valid),
    .hi_data   (hi_data),
    .hi_pause  (hi_pause),
    .lo_valid  (lo_valid),
    .lo_data   (lo_data),
    .lo_pause  (lo_pause),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_pause (out_pause),
    .q_count   (q_count)
);

// File: tb/prio_merge_router_tb.sv
`timescale 1ns/1ps
module prio_merge_router_tb;
    localparam int W = 16;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hi_valid = 1'b0, lo_valid = 1'b0, out_pause = 1'b0;
    logic [W-1:0] hi_data = '0, lo_data = '0;
    logic         hi_pause, lo_pause, out_valid;
    logic [W-1:0] out_data;
    int           checks = 0, errors = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    prio_merge_router #(.DATA_W(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .hi_valid(hi_valid), .hi_data(hi_data), .hi_pause(hi_pause),
        .lo_valid(lo_valid), .lo_data(lo_data), .lo_pause(lo_pause),
        .out_valid(out_valid), .out_data(out_data), .out_pause(out_pause)
    );

    // Advance one edge and settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic hv, input logic [W-1:0] hd, input logic lv, input logic [W-1:0] ld);
        hi_valid = hv; hi_data = hd; lo_valid = lv; lo_data = ld;
        #0.5;
    endtask

    task automatic expect_out(input string req, input logic ev, input logic [W-1:0] ed);
        checks++;
        if (out_valid !== ev || out_data !== ed) begin
            errors++;
            $display("FAIL %s: out valid/data %0b/%0h expected %0b/%0h", req, out_valid, out_data, ev, ed);
        end
    endtask

    task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        expect_out("R1", 1'b0, '0);
        expect_bit("R1", "hi_pause", hi_pause, 1'b0);
        expect_bit("R1", "lo_pause", lo_pause, 1'b0);
    endtask

    task automatic t_idle();
        drive(1'b0, 16'h1111, 1'b0, 16'h2222);
        step();
        expect_out("R2", 1'b0, '0);
    endtask

    task automatic t_single();
        drive(1'b1, 16'hA001, 1'b0, 16'h0);
        step();
        expect_out("R5", 1'b1, 16'hA001);
        drive(1'b0, 16'h0, 1'b1, 16'hB001);
        step();
        expect_out("R4", 1'b1, 16'hB001);
        drive(1'b0, 16'h0, 1'b0, 16'h0);
        step();
        expect_out("R2", 1'b0, '0);
    endtask

    // Both inputs at once: primary forwarded, secondary parked (R6), then drained (R3).
    task automatic t_backlog();
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, W'(16'hC000 + i), 1'b1, W'(16'hD000 + i));
            step();
            expect_out("R6", 1'b1, W'(16'hC000 + i));
        end
        drive(1'b1, 16'hC0FF, 1'b0, 16'h0);
        step();
        expect_out("R5", 1'b1, 16'hC0FF);
        drive(1'b0, 16'h0, 1'b1, 16'hE001);
        step();
        expect_out("R4", 1'b1, 16'hE001);
        drive(1'b0, 16'h0, 1'b0, 16'h0);
        for (int i = 0; i < 3; i++) begin
            step();
            expect_out("R3", 1'b1, W'(16'hD000 + i));
        end
        step();
        expect_out("R2", 1'b0, '0);
    endtask

    // Fill the queue, then a further secondary word is refused (R7, R9).
    task automatic t_full();
        for (int i = 0; i < D; i++) begin
            drive(1'b1, W'(16'h1000 + i), 1'b1, W'(16'h2000 + i));
            expect_bit("R9", "lo_pause before full", lo_pause, 1'b0);
            step();
        end
        drive(1'b1, 16'h1FFF, 1'b1, 16'h2FFF);
        expect_bit("R7", "lo_pause at full", lo_pause, 1'b1);
        step();
        expect_out("R7", 1'b1, 16'h1FFF);
        drive(1'b0, 16'h0, 1'b0, 16'h0);
        for (int i = 0; i < D; i++) begin
            step();
            expect_out("R9", 1'b1, W'(16'h2000 + i));
        end
        step();
        expect_out("R9", 1'b0, '0);
    endtask

    // Consumer stall holds output and pauses both producers (R8).
    task automatic t_stall();
        drive(1'b1, 16'h5A5A, 1'b0, 16'h0);
        step();
        expect_out("R5", 1'b1, 16'h5A5A);
        out_pause = 1'b1;
        drive(1'b1, 16'h6B6B, 1'b1, 16'h7C7C);
        expect_bit("R8", "hi_pause", hi_pause, 1'b1);
        expect_bit("R8", "lo_pause", lo_pause, 1'b1);
        step();
        expect_out("R8", 1'b1, 16'h5A5A);
        step();
        expect_out("R8", 1'b1, 16'h5A5A);
        out_pause = 1'b0;
        #0.5;
        step();
        expect_out("R8", 1'b1, 16'h6B6B);
        drive(1'b0, 16'h0, 1'b0, 16'h0);
        step();
        expect_out("R8", 1'b1, 16'h7C7C);
        step();
        expect_out("R8", 1'b0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        #0.5;
        t_reset();
        t_idle();
        t_single();
        t_backlog();
        t_full();
        t_stall();
        finish_run();
    end
endmodule